// File: doc/BRIEF.md
# Dual-Clock Sample FIFO with Refill Watermarks

This block carries audio samples from a fast computation clock domain into a slower converter clock domain. On the write side a sample-generating state machine pushes samples in bursts. It stops when the block reports full or when occupancy reaches a high threshold. On the read side the converter logic pops one sample per request at its own steady rate, whatever the writer is doing.

Pointers cross between the domains in Gray code through two-flop synchronizers, so the block works for any ratio of the two clocks. The writer receives three flags: full, almost full (a programmable high threshold) and a refill request. The refill request is raised when occupancy drops to a programmable low threshold, and it works as an interrupt that tells the state machine to start its next burst. Both flags are worked out in the write domain. A push into a full FIFO is dropped and a pop from an empty FIFO is dropped. Each of these sets its own sticky error bit. On a dropped pop the output keeps the last sample it delivered, so the converter repeats that sample and no garbage reaches it.

Top module: `sample_cdc_fifo`

## Requirements
- R1: Samples leave on `rdData` in exactly the order in which they were accepted on the write side, including across pointer wraparound.
- R2: `wrFull` is 1 when the writer-side occupancy equals 2^ADDR_W. A write while `wrFull` is 1 is discarded: the stored contents and the write pointer are unchanged.
- R3: `wrOverflowErr` becomes 1 on the first `wrClk` edge at which `wrEn` is 1 while `wrFull` is 1. It stays 1 until `wrRstN` is asserted.
- R4: `rdEmpty` is 1 when the reader sees no unread entry. A read while `rdEmpty` is 1 is discarded and `rdData` keeps the last sample it delivered.
- R5: `rdUnderflowErr` becomes 1 on the first `rdClk` edge at which `rdEn` is 1 while `rdEmpty` is 1. It stays 1 until `rdRstN` is asserted.
- R6: `wrAlmostFull` is 1 exactly when the writer-side occupancy is at least HI_MARK.
- R7: `wrRefillReq` is 1 exactly when the writer-side occupancy is at most LO_MARK. The read position used for this is the one synchronized into the write domain.
- R8: While both resets are asserted, the outputs are: `rdEmpty`=1, `wrFull`=0, `wrAlmostFull`=0, `wrRefillReq`=1, both error bits 0 and `rdData`=0.
- R9: `rdData` changes only on a `rdClk` edge that accepts a read. That edge loads the oldest unread sample.
- R10: Each pointer that crosses domains changes in at most one bit per clock of its own domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Computation (write) clock |
| wrRstN | input | 1 | Asynchronous active-low reset, write domain |
| wrEn | input | 1 | Push request |
| wrData | input | DATA_W | Sample to push |
| wrFull | output | 1 | No free entry as seen by the writer |
| wrAlmostFull | output | 1 | Occupancy at or above HI_MARK |
| wrRefillReq | output | 1 | Occupancy at or below LO_MARK; asks the writer for a burst |
| wrOverflowErr | output | 1 | Sticky: a push was attempted while full |
| rdClk | input | 1 | Converter (read) clock |
| rdRstN | input | 1 | Asynchronous active-low reset, read domain |
| rdEn | input | 1 | Pop request |
| rdData | output | DATA_W | Last sample popped |
| rdEmpty | output | 1 | No unread entry as seen by the reader |
| rdUnderflowErr | output | 1 | Sticky: a pop was attempted while empty |

## Verification
`wrFull` and `wrAlmostFull` follow the write pointer, so they are settled just after the `wrClk` edge that accepts a push. `rdEmpty` clears only after the new write pointer passes two `rdClk` flops. A pop loads `rdData` on its own `rdClk` edge. `wrFull` and `wrRefillReq` see a pop only after two `wrClk` flops. The bench drives every input on a falling edge and reads `rdData` at the falling edge that follows the popping edge. After each single push or pop it waits four edges of both clocks before it compares any flag with an occupancy counted in the bench, so each crossing delay has finished before the comparison.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  // Per-cycle strobes from control to datapath: push is in the write
  // domain, pop in the read domain.
  typedef struct packed {
    logic push;
    logic pop;
  } fifoStrobe_t;
endpackage

// File: rtl/sfifo_sync.sv
module sfifo_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl
  import sfifo_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int HI_MARK = 230,
  parameter int LO_MARK = 26
) (
  input  logic              wrClk,
  input  logic              wrRstN,
  input  logic              wrEn,
  input  logic              rdClk,
  input  logic              rdRstN,
  input  logic              rdEn,
  output fifoStrobe_t       strobe,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              wrFull,
  output logic              wrAlmostFull,
  output logic              wrRefillReq,
  output logic              wrOverflowErr,
  output logic              rdEmpty,
  output logic              rdUnderflowErr
);
  localparam int PTR_W = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [PTR_W-1:0] DEPTH_C = PTR_W'(DEPTH);
  localparam logic [PTR_W-1:0] HI_C    = PTR_W'(HI_MARK);
  localparam logic [PTR_W-1:0] LO_C    = PTR_W'(LO_MARK);
  localparam logic [PTR_W-1:0] ONE_C   = PTR_W'(1);

  function automatic logic [PTR_W-1:0] toGray(input logic [PTR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_W-1:0] fromGray(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

  // ---------------- write domain ----------------
  logic [PTR_W-1:0] wrBin, wrGray, rdGrayInWr, wrUsed, wrBinInc;
  logic [PTR_W-1:0] rdBin, rdGray, wrGrayInRd, rdBinInc;
  logic             wrPush, rdPop;

  sfifo_sync #(.W(PTR_W)) syncRdToWr (
    .clk (wrClk),
    .rstN(wrRstN),
    .d   (rdGray),
    .q   (rdGrayInWr)
  );

  assign wrBinInc     = wrBin + ONE_C;
  assign wrUsed       = wrBin - fromGray(rdGrayInWr);
  assign wrFull       = (wrUsed == DEPTH_C);
  assign wrAlmostFull = (wrUsed >= HI_C);
  assign wrRefillReq  = (wrUsed <= LO_C);
  assign wrPush       = wrEn & ~wrFull;

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      wrBin         <= '0;
      wrGray        <= '0;
      wrOverflowErr <= 1'b0;
    end else begin
      if (wrPush) begin
        wrBin  <= wrBinInc;
        wrGray <= toGray(wrBinInc);
      end
      if (wrEn && wrFull) begin
        wrOverflowErr <= 1'b1;
      end
    end
  end

  // ---------------- read domain ----------------
  sfifo_sync #(.W(PTR_W)) syncWrToRd (
    .clk (rdClk),
    .rstN(rdRstN),
    .d   (wrGray),
    .q   (wrGrayInRd)
  );

  assign rdBinInc = rdBin + ONE_C;
  assign rdEmpty  = (rdGray == wrGrayInRd);
  assign rdPop    = rdEn & ~rdEmpty;

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      rdBin          <= '0;
      rdGray         <= '0;
      rdUnderflowErr <= 1'b0;
    end else begin
      if (rdPop) begin
        rdBin  <= rdBinInc;
        rdGray <= toGray(rdBinInc);
      end
      if (rdEn && rdEmpty) begin
        rdUnderflowErr <= 1'b1;
      end
    end
  end

  assign strobe.push = wrPush;
  assign strobe.pop  = rdPop;
  assign wrAddr      = wrBin[ADDR_W-1:0];
  assign rdAddr      = rdBin[ADDR_W-1:0];

  // ---------------- assertions ----------------
  AST_WR_GRAY_STEP: assert property (@(posedge wrClk) disable iff (!wrRstN)
    $countones(wrGray ^ $past(wrGray)) <= 1); // R10
  AST_RD_GRAY_STEP: assert property (@(posedge rdClk) disable iff (!rdRstN)
    $countones(rdGray ^ $past(rdGray)) <= 1); // R10
  AST_NO_OVERFLOW: assert property (@(posedge wrClk) disable iff (!wrRstN)
    (wrEn && wrFull) |=> $stable(wrBin)); // R2
  AST_NO_UNDERFLOW: assert property (@(posedge rdClk) disable iff (!rdRstN)
    (rdEn && rdEmpty) |=> $stable(rdBin)); // R4
  AST_OVF_STICKY: assert property (@(posedge wrClk) disable iff (!wrRstN)
    wrOverflowErr |=> wrOverflowErr); // R3
  AST_UDF_STICKY: assert property (@(posedge rdClk) disable iff (!rdRstN)
    rdUnderflowErr |=> rdUnderflowErr); // R5
  AST_USED_BOUND: assert property (@(posedge wrClk) disable iff (!wrRstN)
    wrUsed <= DEPTH_C); // R2
endmodule

// File: rtl/sfifo_path.sv
module sfifo_path
  import sfifo_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int ADDR_W = 8
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rdRstN,
  input  fifoStrobe_t       strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strobe.push) begin
      store[wrAddr] <= wrData;
    end
  end

  // Output holds its last value unless a pop is accepted, so an
  // underflow repeats the previous sample.
  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      rdData <= '0;
    end else if (strobe.pop) begin
      rdData <= store[rdAddr];
    end
  end

  AST_DATA_HOLD: assert property (@(posedge rdClk) disable iff (!rdRstN)
    !strobe.pop |=> $stable(rdData)); // R9
endmodule

// File: rtl/sample_cdc_fifo.sv
module sample_cdc_fifo
  import sfifo_pkg::*;
#(
  parameter int DATA_W  = 24,
  parameter int ADDR_W  = 8,
  parameter int HI_MARK = 230,
  parameter int LO_MARK = 26
) (
  input  logic              wrClk,
  input  logic              wrRstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrFull,
  output logic              wrAlmostFull,
  output logic              wrRefillReq,
  output logic              wrOverflowErr,
  input  logic              rdClk,
  input  logic              rdRstN,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdEmpty,
  output logic              rdUnderflowErr
);
  fifoStrobe_t       strobe;
  logic [ADDR_W-1:0] wrAddr, rdAddr;

  sfifo_ctrl #(.ADDR_W(ADDR_W), .HI_MARK(HI_MARK), .LO_MARK(LO_MARK)) ctrl (
    .wrClk         (wrClk),
    .wrRstN        (wrRstN),
    .wrEn          (wrEn),
    .rdClk         (rdClk),
    .rdRstN        (rdRstN),
    .rdEn          (rdEn),
    .strobe        (strobe),
    .wrAddr        (wrAddr),
    .rdAddr        (rdAddr),
    .wrFull        (wrFull),
    .wrAlmostFull  (wrAlmostFull),
    .wrRefillReq   (wrRefillReq),
    .wrOverflowErr (wrOverflowErr),
    .rdEmpty       (rdEmpty),
    .rdUnderflowErr(rdUnderflowErr)
  );

  sfifo_path #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) path (
    .wrClk (wrClk),
    .rdClk (rdClk),
    .rdRstN(rdRstN),
    .strobe(strobe),
    .wrAddr(wrAddr),
    .rdAddr(rdAddr),
    .wrData(wrData),
    .rdData(rdData)
  );
endmodule

// File: tb/sample_cdc_fifo_test.sv
`timescale 1ns/1ps
module sample_cdc_fifo_test;
  localparam int DW = 24;
  localparam int AW = 3;
  localparam int DEPTH = 1 << AW;
  localparam int HI = 6;
  localparam int LO = 2;
  localparam int STREAM_N = 20;

  logic          wrClk = 1'b0, rdClk = 1'b0;
  logic          wrRstN = 1'b0, rdRstN = 1'b0;
  logic          wrEn = 1'b0, rdEn = 1'b0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic          wrFull, wrAlmostFull, wrRefillReq, wrOverflowErr;
  logic          rdEmpty, rdUnderflowErr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 wrClk = ~wrClk;   // 250 MHz
  always #5 rdClk = ~rdClk;   // slower converter clock

  sample_cdc_fifo #(.DATA_W(DW), .ADDR_W(AW), .HI_MARK(HI), .LO_MARK(LO)) uut (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrEn(wrEn), .wrData(wrData),
    .wrFull(wrFull), .wrAlmostFull(wrAlmostFull), .wrRefillReq(wrRefillReq),
    .wrOverflowErr(wrOverflowErr),
    .rdClk(rdClk), .rdRstN(rdRstN), .rdEn(rdEn), .rdData(rdData),
    .rdEmpty(rdEmpty), .rdUnderflowErr(rdUnderflowErr)
  );

  function automatic logic [DW-1:0] pattern(input int i);
    return DW'(i * 32'h010203) ^ 24'hA50000;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge rdClk);
    repeat (4) @(negedge wrClk);
  endtask

  task automatic pushOne(input logic [DW-1:0] d);
    @(negedge wrClk);
    wrEn = 1'b1; wrData = d;
    @(negedge wrClk);
    wrEn = 1'b0;
  endtask

  task automatic popOne();
    @(negedge rdClk);
    rdEn = 1'b1;
    @(negedge rdClk);
    rdEn = 1'b0;
  endtask

  task automatic checkFlags(input int cnt);
    check("R2 full",        32'(wrFull),       32'(cnt == DEPTH));
    check("R6 almost full", 32'(wrAlmostFull), 32'(cnt >= HI));
    check("R7 refill",      32'(wrRefillReq),  32'(cnt <= LO));
    check("R4 empty",       32'(rdEmpty),      32'(cnt == 0));
  endtask

  initial begin
    #400000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int cnt;
    repeat (3) @(negedge rdClk);
    // R8 reset state
    check("R8 empty",     32'(rdEmpty),        32'd1);
    check("R8 full",      32'(wrFull),         32'd0);
    check("R8 afull",     32'(wrAlmostFull),   32'd0);
    check("R8 refill",    32'(wrRefillReq),    32'd1);
    check("R8 ovf",       32'(wrOverflowErr),  32'd0);
    check("R8 udf",       32'(rdUnderflowErr), 32'd0);
    check("R8 data",      32'(rdData),         32'd0);
    @(negedge wrClk); wrRstN = 1'b1;
    @(negedge rdClk); rdRstN = 1'b1;
    settle();

    // Fill sweep over every occupancy
    cnt = 0;
    for (int i = 1; i <= DEPTH; i++) begin
      pushOne(pattern(i));
      cnt++;
      settle();
      checkFlags(cnt);
    end

    // Push while full: dropped, sticky error (R2, R3)
    pushOne(24'hDEAD00);
    settle();
    check("R3 overflow flag", 32'(wrOverflowErr), 32'd1);
    check("R2 still full",    32'(wrFull),        32'd1);
    check("R5 no udf yet",    32'(rdUnderflowErr), 32'd0);

    // Drain sweep in order (R1, R9)
    for (int i = 1; i <= DEPTH; i++) begin
      popOne();
      check("R1/R9 order", 32'(rdData), 32'(pattern(i)));
      cnt--;
      settle();
      check("R9 hold", 32'(rdData), 32'(pattern(i)));
      checkFlags(cnt);
    end

    // Pop while empty: dropped, data repeated (R4, R5)
    popOne();
    check("R4 repeat last", 32'(rdData), 32'(pattern(DEPTH)));
    settle();
    check("R5 underflow flag", 32'(rdUnderflowErr), 32'd1);
    check("R4 still empty",    32'(rdEmpty),        32'd1);
    check("R3 sticky",         32'(wrOverflowErr),  32'd1);

    // Concurrent streaming with wraparound (R1)
    fork
      begin
        for (int k = 0; k < STREAM_N; k++) begin
          @(negedge wrClk);
          while (wrFull) @(negedge wrClk);
          wrEn = 1'b1; wrData = 24'h100000 + DW'(k * 7);
          @(negedge wrClk);
          wrEn = 1'b0;
        end
      end
      begin
        for (int k = 0; k < STREAM_N; k++) begin
          @(negedge rdClk);
          while (rdEmpty) @(negedge rdClk);
          rdEn = 1'b1;
          @(negedge rdClk);
          rdEn = 1'b0;
          check("R1 stream order", 32'(rdData), 32'(24'h100000 + DW'(k * 7)));
        end
      end
    join
    settle();
    checkFlags(0);
    check("R5 sticky", 32'(rdUnderflowErr), 32'd1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule